// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio P·N + A. A model of a two-modulus prescaler divides the input clock by P or by P+1. A swallow counter keeps the prescaler at P+1 for the first A prescaler cycles of every division period. A main counter ends the period after N prescaler cycles. Each completed period produces one comparison pulse, which goes to a phase detector outside this block. Because the prescaler does the fast counting, no counter as wide as the full ratio has to run at the input clock rate.

A build-time family parameter picks one of two modulus pairs. A select bit then picks the lower or the upper pair within that family. New values for select, A and N arrive on a single-cycle load strobe and are checked first. A legal set is held as pending and takes effect at the next division boundary, so no period ever runs with mixed settings. An illegal set raises an error pulse and is discarded.

The output pulse is a plain timing event with no back-pressure: it carries no payload, and no consumer can stall it. The load strobe is a plain control input and has no ready signal, because a load is accepted, or rejected with an error, in the cycle it is presented.

Top module: `psd_top`

## Requirements
- R1: Consecutive `fp` pulses are exactly P·N + A input cycles apart, where A and N are the values active for that division period.
- R2: `fp` is high for exactly one input cycle per division period.
- R3: P is set by the family and the select bit. With family low, P is 32 when select = 1 and 64 when select = 0. With family high, P is 64 when select = 1 and 128 when select = 0. The prescaler divides by P+1 while the swallow count is nonzero.
- R4: In every period, `mod_ctl` is high for exactly A·(P+1) input cycles, all at the start of the period, and changes only where one prescaler cycle ends. With A = 0 it stays low for the whole period.
- R5: A load with N < 3 raises `cfg_err` for one cycle, in the cycle after the strobe, and changes neither the active nor the pending settings.
- R6: A load with A ≥ N (and N ≥ 3) is rejected in the same way as in R5. A legal load raises no error.
- R7: A legal load takes effect for the division period that begins after the period in progress ends. The period in progress finishes with its old ratio. A load captured on the same edge as a boundary applies one period later.
- R8: During reset `fp` and `cfg_err` are low and `mod_ctl` equals (RST_A ≠ 0). The first `fp` after reset comes P·RST_N + RST_A cycles after reset is released.
- R9: If several legal loads arrive within one period, the last one takes effect. A rejected load does not disturb a pending legal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that presents a new setting |
| cfg_sel | input | 1 | Modulus select bit (1 = lower pair of the family) |
| cfg_a | input | 7 | Swallow count A, 0 to 127 |
| cfg_n | input | 11 | Main count N, 3 to 2047 |
| fp | output | 1 | One-cycle pulse per completed division |
| mod_ctl | output | 1 | Modulus control; high while the prescaler divides by P+1 |
| cfg_err | output | 1 | One-cycle pulse after a rejected load |

## Verification
The hardest case to reach is a load captured on the very edge where a period ends. The setting must then wait a full extra period, and this cannot be aimed at from the ports without predicting the boundary. The bench runs two instances of different families side by side on the same load stream. Their boundaries drift apart, so across the sweep of A and N the loads fall at many offsets, including boundary edges. The bench model resolves the boundary before it captures the load, just as the specification orders them. A = N − 1 and A = 0 are swept for every N from 3 to 7, and illegal loads are placed between legal pending ones.

// File: rtl/psd_pkg.sv
package psd_pkg;

  localparam int unsigned PSD_A_W   = 7;
  localparam int unsigned PSD_N_W   = 11;
  localparam int unsigned PSD_N_MIN = 3;

  typedef enum logic {
    FAM_LOW  = 1'b0,
    FAM_HIGH = 1'b1
  } psd_family_e;

  typedef struct packed {
    logic               sel;
    logic [PSD_A_W-1:0] a;
    logic [PSD_N_W-1:0] n;
  } psd_cfg_t;

  // Smallest lower modulus of a family
  function automatic int unsigned fam_base(psd_family_e f);
    return (f == FAM_LOW) ? 32 : 64;
  endfunction

  // Lower modulus P for a family and select bit
  function automatic int unsigned low_mod(psd_family_e f, logic sel);
    return sel ? fam_base(f) : 2 * fam_base(f);
  endfunction

  function automatic logic cfg_legal(psd_cfg_t c);
    return (c.n >= PSD_N_W'(PSD_N_MIN)) && (PSD_N_W'(c.a) < c.n);
  endfunction

endpackage

// File: rtl/psd_cfg_stage.sv
module psd_cfg_stage
  import psd_pkg::*;
#(
  parameter psd_cfg_t RST_CFG = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld,
  input  psd_cfg_t ld_cfg,
  input  logic     bnd,
  output psd_cfg_t act,
  output psd_cfg_t nxt,
  output logic     err
);

  psd_cfg_t pend;
  logic     pend_v;
  logic     ld_ok;

  assign ld_ok = cfg_legal(ld_cfg);
  // Setting that the coming boundary installs
  assign nxt   = pend_v ? pend : act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= RST_CFG;
      pend   <= RST_CFG;
      pend_v <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= ld & ~ld_ok;
      if (bnd) act <= nxt;
      if (ld && ld_ok) begin
        pend   <= ld_cfg;
        pend_v <= 1'b1;
      end else if (bnd) begin
        pend_v <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter psd_family_e FAM     = FAM_LOW,
  parameter logic        RST_SEL = 1'b1,
  parameter logic        RST_HI  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_sel,
  input  logic ld_hi,
  output logic tc
);

  localparam int unsigned MAX_MOD = 2 * fam_base(FAM) + 1;
  localparam int unsigned PC_W    = $clog2(MAX_MOD + 1);

  function automatic logic [PC_W-1:0] reload(logic sel, logic hi);
    return PC_W'(low_mod(FAM, sel) + (hi ? 32'd1 : 32'd0) - 32'd1);
  endfunction

  logic [PC_W-1:0] cnt;

  assign tc = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= reload(RST_SEL, RST_HI);
    else if (tc) cnt <= reload(ld_sel, ld_hi);
    else         cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
  import psd_pkg::*;
#(
  parameter int unsigned RST_A = 1,
  parameter int unsigned RST_N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tc,
  input  logic [PSD_A_W-1:0] nxt_a,
  input  logic [PSD_N_W-1:0] nxt_n,
  output logic               mc,
  output logic               mc_next,
  output logic               bnd
);

  logic [PSD_A_W-1:0] sw;
  logic [PSD_N_W-1:0] nrem;

  assign bnd     = tc && (nrem == PSD_N_W'(1));
  assign mc      = (sw != '0);
  // Modulus for the prescaler cycle starting after this terminal count
  assign mc_next = bnd ? (nxt_a != '0) : (sw > PSD_A_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw   <= PSD_A_W'(RST_A);
      nrem <= PSD_N_W'(RST_N);
    end else if (tc) begin
      if (bnd) begin
        sw   <= nxt_a;
        nrem <= nxt_n;
      end else begin
        if (sw != '0) sw <= sw - 1'b1;
        nrem <= nrem - 1'b1;
      end
    end
  end

endmodule

// File: rtl/psd_top.sv
module psd_top
  import psd_pkg::*;
#(
  parameter psd_family_e FAM     = FAM_LOW,
  parameter logic        RST_SEL = 1'b1,
  parameter int unsigned RST_A   = 1,
  parameter int unsigned RST_N   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic               cfg_sel,
  input  logic [PSD_A_W-1:0] cfg_a,
  input  logic [PSD_N_W-1:0] cfg_n,
  output logic               fp,
  output logic               mod_ctl,
  output logic               cfg_err
);

  localparam psd_cfg_t RST_CFG = '{sel: RST_SEL, a: PSD_A_W'(RST_A), n: PSD_N_W'(RST_N)};
  localparam logic     RST_HI  = (RST_A != 0);

  psd_cfg_t           ld_cfg;
  psd_cfg_t           act_cfg;
  psd_cfg_t           nxt_cfg;
  logic               pre_tc;
  logic               bnd;
  logic               mc_q;
  logic               mc_nxt;
  logic               pre_sel;
  logic [PSD_A_W-1:0] act_a;
  logic [PSD_N_W-1:0] act_n;

  assign ld_cfg  = '{sel: cfg_sel, a: cfg_a, n: cfg_n};
  assign pre_sel = bnd ? nxt_cfg.sel : act_cfg.sel;
  assign act_a   = act_cfg.a;
  assign act_n   = act_cfg.n;
  assign mod_ctl = mc_q;

  psd_cfg_stage #(.RST_CFG(RST_CFG)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (cfg_load),
    .ld_cfg (ld_cfg),
    .bnd    (bnd),
    .act    (act_cfg),
    .nxt    (nxt_cfg),
    .err    (cfg_err)
  );

  psd_prescaler #(.FAM(FAM), .RST_SEL(RST_SEL), .RST_HI(RST_HI)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_sel (pre_sel),
    .ld_hi  (mc_nxt),
    .tc     (pre_tc)
  );

  psd_swallow #(.RST_A(RST_A), .RST_N(RST_N)) u_swl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tc      (pre_tc),
    .nxt_a   (nxt_cfg.a),
    .nxt_n   (nxt_cfg.n),
    .mc      (mc_q),
    .mc_next (mc_nxt),
    .bnd     (bnd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fp <= 1'b0;
    else        fp <= bnd;
  end

endmodule

// File: rtl/psd_chk.sv
module psd_chk
  import psd_pkg::*;
#(
  parameter psd_family_e FAM = FAM_LOW
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fp,
  input logic               cfg_load,
  input logic [PSD_A_W-1:0] cfg_a,
  input logic [PSD_N_W-1:0] cfg_n,
  input logic               cfg_err,
  input logic               mod_ctl,
  input logic               pre_tc,
  input logic               bnd,
  input logic [PSD_A_W-1:0] act_a,
  input logic [PSD_N_W-1:0] act_n
);

  localparam int unsigned MIN_GAP = PSD_N_MIN * fam_base(FAM);

  logic [31:0] gap;
  logic        n_low;
  logic        a_big;

  assign n_low = (cfg_n < PSD_N_W'(PSD_N_MIN));
  assign a_big = (PSD_N_W'(cfg_a) >= cfg_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else        gap <= fp ? 32'd1 : gap + 32'd1;
  end

  AST_FP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fp |=> !fp); // R2
  AST_FP_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n) fp |-> gap >= MIN_GAP); // R1
  AST_ERR_SHORT_N: assert property (@(posedge clk) disable iff (!rst_n) (cfg_load && n_low) |=> cfg_err); // R5
  AST_ERR_BIG_A: assert property (@(posedge clk) disable iff (!rst_n) (cfg_load && !n_low && a_big) |=> cfg_err); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_load && (n_low || a_big)) |=> !cfg_err); // R6
  AST_MC_AT_TC: assert property (@(posedge clk) disable iff (!rst_n) !pre_tc |=> $stable(mod_ctl)); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bnd |=> ($stable(act_a) && $stable(act_n))); // R7

endmodule

bind psd_top psd_chk #(.FAM(FAM)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fp       (fp),
  .cfg_load (cfg_load),
  .cfg_a    (cfg_a),
  .cfg_n    (cfg_n),
  .cfg_err  (cfg_err),
  .mod_ctl  (mod_ctl),
  .pre_tc   (pre_tc),
  .bnd      (bnd),
  .act_a    (act_a),
  .act_n    (act_n)
);

// File: tb/tb_psd_top.sv
`timescale 1ns/1ps
module tb_psd_top;
  import psd_pkg::*;

  localparam int WD_LIMIT = 190000;
  localparam int RST_A    = 1;
  localparam int RST_N    = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld;
  logic       sel;
  logic [6:0] a;
  logic [10:0] n;
  logic [1:0] fpv, mcv, erv;

  always #2.5 clk = ~clk;

  psd_top #(.FAM(FAM_LOW), .RST_SEL(1'b1), .RST_A(RST_A), .RST_N(RST_N)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(ld), .cfg_sel(sel), .cfg_a(a), .cfg_n(n),
    .fp(fpv[0]), .mod_ctl(mcv[0]), .cfg_err(erv[0]));

  psd_top #(.FAM(FAM_HIGH), .RST_SEL(1'b1), .RST_A(RST_A), .RST_N(RST_N)) dut_hi (
    .clk(clk), .rst_n(rst_n), .cfg_load(ld), .cfg_sel(sel), .cfg_a(a), .cfg_n(n),
    .fp(fpv[1]), .mod_ctl(mcv[1]), .cfg_err(erv[1]));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string phase = "R1/R3";

  int base[2] = '{32, 64};
  bit cur_s[2]; int cur_a[2]; int cur_n[2];
  bit pnd_s[2]; int pnd_a[2]; int pnd_n[2]; bit pnd_v[2];
  int cnt[2]; int mcc[2]; int nfp[2];

  bit cap_ld; bit cap_sel; int cap_a; int cap_n;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int pval(int b, bit s);
    return s ? b : 2 * b;
  endfunction

  task automatic monitor(input int i);
    cnt[i]++;
    if (fpv[i]) begin
      // period ending: P*N+A, mod_ctl high A*(P+1) cycles
      chk(cnt[i] == pval(base[i], cur_s[i]) * cur_n[i] + cur_a[i],
          (nfp[i] == 0) ? "R8" : phase, cnt[i],
          pval(base[i], cur_s[i]) * cur_n[i] + cur_a[i]);
      chk(mcc[i] == cur_a[i] * (pval(base[i], cur_s[i]) + 1), "R4", mcc[i],
          cur_a[i] * (pval(base[i], cur_s[i]) + 1));
      cnt[i] = 0;
      nfp[i]++;
      if (pnd_v[i]) begin
        cur_s[i] = pnd_s[i]; cur_a[i] = pnd_a[i]; cur_n[i] = pnd_n[i];
        pnd_v[i] = 1'b0;
      end
      mcc[i] = int'(mcv[i]);
    end else begin
      mcc[i] += int'(mcv[i]);
    end
    if (cap_ld) begin
      bit ok;
      ok = (cap_n >= 3) && (cap_a < cap_n);
      chk(erv[i] == !ok, (cap_n < 3) ? "R5" : "R6", int'(erv[i]), int'(!ok));
      if (ok) begin
        pnd_s[i] = cap_sel; pnd_a[i] = cap_a; pnd_n[i] = cap_n; pnd_v[i] = 1'b1;
      end
    end else if (erv[i]) begin
      chk(1'b0, "R6", 1, 0);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    cap_ld = ld; cap_sel = sel; cap_a = int'(a); cap_n = int'(n);
    @(negedge clk);
    cyc++;
    for (int i = 0; i < 2; i++) monitor(i);
    ld = 1'b0;
    if (cyc > WD_LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
      finish_run();
    end
  endtask

  task automatic load(input bit s, input int aa, input int nn);
    sel = s; a = 7'(aa); n = 11'(nn); ld = 1'b1;
    tick();
  endtask

  task automatic wait_fp(input int k);
    int s0, s1;
    s0 = nfp[0]; s1 = nfp[1];
    while (nfp[0] < s0 + k || nfp[1] < s1 + k) tick();
  endtask

  initial begin
    rst_n = 1'b0; ld = 1'b0; sel = 1'b1; a = '0; n = 11'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(fpv[i] == 1'b0, "R8", int'(fpv[i]), 0);
      chk(erv[i] == 1'b0, "R8", int'(erv[i]), 0);
      chk(mcv[i] == (RST_A != 0), "R8", int'(mcv[i]), int'(RST_A != 0));
      cur_s[i] = 1'b1; cur_a[i] = RST_A; cur_n[i] = RST_N; pnd_v[i] = 1'b0;
      cnt[i] = 0; nfp[i] = 0; mcc[i] = int'(mcv[i]);
    end
    rst_n = 1'b1;
    wait_fp(2);

    // R1/R3 sweep of A and N in the lower pair
    phase = "R1/R3";
    for (int nn = 3; nn <= 7; nn++)
      for (int aa = 0; aa < nn; aa++) begin
        load(1'b1, aa, nn);
        wait_fp(2);
      end

    // R3 upper pair of each family
    load(1'b0, 2, 3); wait_fp(2);
    load(1'b0, 0, 4); wait_fp(2);

    // R5 / R6 rejected loads leave the running setting in place
    phase = "R5/R6";
    load(1'b1, 0, 2);
    load(1'b1, 0, 0);
    load(1'b1, 3, 3);
    load(1'b1, 9, 4);
    wait_fp(2);

    // R7 load mid-period, in-progress period keeps old ratio
    phase = "R7";
    repeat (40) tick();
    load(1'b1, 2, 3);
    wait_fp(2);

    // R9 last legal load wins, rejected load keeps pending one
    phase = "R9";
    load(1'b1, 1, 5);
    load(1'b1, 2, 6);
    wait_fp(3);
    load(1'b1, 4, 9);
    load(1'b1, 0, 1);
    wait_fp(3);

    // R1 large swallow count
    phase = "R1";
    load(1'b1, 127, 200);
    wait_fp(2);

    finish_run();
  end

endmodule